// File: doc/BRIEF.md
# Multi-Source Interrupt Routing Registers

This block holds six interrupt routing registers, one for each interrupt input. Every register stores a destination server, a priority and a source number. It also carries a pending flag that the block maintains itself. Input changes arrive as single events, each naming an input index and its new level. The block records the level in a status bit and recomputes the pending flag of that input. It drives one output line for each source number toward a downstream interrupt controller. With each line it supplies the server and the priority configured for that line.

A 64-bit register port writes the routing fields. A combinational read port returns the routing registers, a control word and a read-only status word. Input 0 shares its line and its status word with a second "peer" status bit, which a level input drives. The common line stays high, and input 0 still counts as asserted, while either bit is set.

A priority of all ones masks an input. Masking clears the pending flag and blocks it from being set, but does not gate the output line.

Top module: `irq_route_bank`

## Requirements
- R1: After reset, each routing register n holds server 0, priority 0xFF, source number n and pending 0. All status bits, all lines and all pending flags are 0. Line k's configuration then shows priority 0xFF and server 0.
- R2: A write to address n (0 to 5) loads server from wr_data[55:40], priority from [39:32] and source from [31:29]. Readback shows those fields at the same positions and zero in every other bit except the pending flag at bit 24. A write never sets the pending flag, and an unmasked write keeps it unchanged.
- R3: A write whose priority field is 0xFF clears that register's pending flag.
- R4: An event on input n sets pending when the effective state is asserted and the priority is not 0xFF, and clears it otherwise. Nothing else changes pending except a masked write.
- R5: Input 0's status is bit 46 of the control word (read address 6), and the peer status is bit 47 of that word. Inputs 1 to 5 use bits 36, 35, 34, 33 and 32 of the status word (read address 7). Each status bit follows the last event level, and the peer bit follows peer_level.
- R6: For input 0, the effective state is its own level OR the peer bit. A deassert event on input 0 while the peer bit is set therefore leaves pending set, and the shared line stays high until both bits clear.
- R7: line_out[k] is high exactly when some input whose source field equals k has its effective state asserted, whether or not that input is masked.
- R8: For line k, the lowest-index register whose source field is k supplies line_server[k] (its server shifted right by two) and line_prio[k], and line_cfg_valid[k] is 1. If no register names k, the valid bit and both fields are 0. Source numbers 6 and 7 are stored but reach no line.
- R9: An event with index 6 or 7 changes nothing. A write to address 6 or 7 changes nothing.
- R10: Every output and readback value reflects an event or write one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address; 0 to 5 select a routing register |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read address; 0 to 5 routing, 6 control, 7 status |
| rd_data | output | 64 | Read data (combinational) |
| ev_valid | input | 1 | Input change event strobe |
| ev_idx | input | 3 | Index of the input that changed |
| ev_level | input | 1 | New level of that input |
| peer_level | input | 1 | Level of the peer status sharing input 0's line |
| line_out | output | 6 | One interrupt line per source number |
| line_server | output | 84 | Per line, 14-bit server (line k at [14k+13:14k]) |
| line_prio | output | 48 | Per line, 8-bit priority (line k at [8k+7:8k]) |
| line_cfg_valid | output | 6 | Per line, set when some register names this source |

## Verification
A corrupted pending flag shows up as a wrong bit 24 in the readback of that register on the next cycle. A stuck or misplaced status bit shows up in the control or status word and on the corresponding line. A wrong source field moves a line or its server and priority, which the per-line outputs reveal as soon as the register is written. The bench tracks the block in a model and compares every readback address and every line output after each cycle. As a result, any divergence appears within one clock of the event or write that caused it.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    localparam int NUM_IN    = 6;
    localparam int SRV_W     = 16;
    localparam int PRIO_W    = 8;
    localparam int SRC_W     = 3;
    localparam int DATA_W    = 64;
    localparam int LINK_BITS = 2;
    localparam int DS_SRV_W  = SRV_W - LINK_BITS;

    // field positions in a routing word
    localparam int SRV_LSB  = 40;
    localparam int PRIO_LSB = 32;
    localparam int SRC_LSB  = 29;
    localparam int PEND_BIT = 24;

    // control word: own status of input 0 and its peer
    localparam int CTL_OWN_BIT  = 46;
    localparam int CTL_PEER_BIT = 47;
    // status word: input n (n >= 1) at STAT_TOP_BIT - n
    localparam int STAT_TOP_BIT = 37;

    typedef struct packed {
        logic [SRV_W-1:0]  server;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  src;
        logic              pend;
    } route_t;

    function automatic route_t route_default(input int idx);
        route_t r;
        r.server = '0;
        r.prio   = '1;
        r.src    = SRC_W'(idx);
        r.pend   = 1'b0;
        return r;
    endfunction

    function automatic logic is_masked(input logic [PRIO_W-1:0] p);
        return &p;
    endfunction

    function automatic logic [DATA_W-1:0] route_pack(input route_t r);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SRV_LSB +: SRV_W]   = r.server;
        w[PRIO_LSB +: PRIO_W] = r.prio;
        w[SRC_LSB +: SRC_W]   = r.src;
        w[PEND_BIT]           = r.pend;
        return w;
    endfunction

endpackage

// File: rtl/route_entry.sv
`timescale 1ns/1ps
module route_entry
    import irq_route_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_hit,
    input  logic              ev_eff,
    output route_t            q
);

    route_t nxt;

    always_comb begin
        nxt = q;
        if (wr_hit) begin
            nxt.server = wr_data[SRV_LSB +: SRV_W];
            nxt.prio   = wr_data[PRIO_LSB +: PRIO_W];
            nxt.src    = wr_data[SRC_LSB +: SRC_W];
        end
        // mask takes effect with the write that sets it
        if (is_masked(nxt.prio)) begin
            nxt.pend = 1'b0;
        end else if (ev_hit) begin
            nxt.pend = ev_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= route_default(IDX);
        else     q <= nxt;
    end

endmodule

// File: rtl/line_fanout.sv
`timescale 1ns/1ps
module line_fanout
    import irq_route_pkg::*;
#(
    parameter int N_IN    = NUM_IN,
    parameter int N_LINES = NUM_IN
) (
    input  route_t                        ent [N_IN],
    input  logic [N_IN-1:0]               lvl,
    output logic [N_LINES-1:0]            line_out,
    output logic [N_LINES*DS_SRV_W-1:0]   line_server,
    output logic [N_LINES*PRIO_W-1:0]     line_prio,
    output logic [N_LINES-1:0]            line_cfg_valid
);

    always_comb begin
        line_out       = '0;
        line_server    = '0;
        line_prio      = '0;
        line_cfg_valid = '0;
        for (int k = 0; k < N_LINES; k++) begin
            // descending scan so the lowest index is written last and wins
            for (int n = N_IN - 1; n >= 0; n--) begin
                if (ent[n].src == SRC_W'(k)) begin
                    line_out[k] = line_out[k] | lvl[n];
                    line_server[k*DS_SRV_W +: DS_SRV_W] = ent[n].server[SRV_W-1:LINK_BITS];
                    line_prio[k*PRIO_W +: PRIO_W]       = ent[n].prio;
                    line_cfg_valid[k]                   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_route_bank.sv
`timescale 1ns/1ps
module irq_route_bank
    import irq_route_pkg::*;
#(
    parameter int N_IN = NUM_IN
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [2:0]                  rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    input  logic                        ev_valid,
    input  logic [2:0]                  ev_idx,
    input  logic                        ev_level,
    input  logic                        peer_level,
    output logic [N_IN-1:0]             line_out,
    output logic [N_IN*DS_SRV_W-1:0]    line_server,
    output logic [N_IN*PRIO_W-1:0]      line_prio,
    output logic [N_IN-1:0]             line_cfg_valid
);

    localparam int ADDR_W   = 3;
    localparam int CTL_ADDR = N_IN;
    localparam int STS_ADDR = N_IN + 1;

    route_t            ent [N_IN];
    logic [N_IN-1:0]   stat_q;
    logic              peer_q;
    logic [N_IN-1:0]   lvl;
    logic [N_IN-1:0]   pend_q;
    logic [N_IN-1:0]   masked_q;

    // status: event levels and the peer bit
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            peer_q <= 1'b0;
        end else begin
            peer_q <= peer_level;
            for (int n = 0; n < N_IN; n++) begin
                if (ev_valid && ev_idx == ADDR_W'(n)) stat_q[n] <= ev_level;
            end
        end
    end

    generate
        for (genvar n = 0; n < N_IN; n++) begin : g_entry
            logic eff;
            if (n == 0) begin : g_shared
                assign eff    = ev_level | peer_level;
                assign lvl[n] = stat_q[n] | peer_q;
            end else begin : g_plain
                assign eff    = ev_level;
                assign lvl[n] = stat_q[n];
            end

            route_entry #(.IDX(n)) u_entry (
                .clk     (clk),
                .rst     (rst),
                .wr_hit  (wr_en && wr_addr == ADDR_W'(n)),
                .wr_data (wr_data),
                .ev_hit  (ev_valid && ev_idx == ADDR_W'(n)),
                .ev_eff  (eff),
                .q       (ent[n])
            );

            assign pend_q[n]   = ent[n].pend;
            assign masked_q[n] = is_masked(ent[n].prio);
        end
    endgenerate

    line_fanout #(.N_IN(N_IN), .N_LINES(N_IN)) u_fanout (
        .ent            (ent),
        .lvl            (lvl),
        .line_out       (line_out),
        .line_server    (line_server),
        .line_prio      (line_prio),
        .line_cfg_valid (line_cfg_valid)
    );

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < N_IN; n++) begin
            if (rd_addr == ADDR_W'(n)) rd_data = route_pack(ent[n]);
        end
        if (rd_addr == ADDR_W'(CTL_ADDR)) begin
            rd_data[CTL_OWN_BIT]  = stat_q[0];
            rd_data[CTL_PEER_BIT] = peer_q;
        end
        if (rd_addr == ADDR_W'(STS_ADDR)) begin
            for (int n = 1; n < N_IN; n++) rd_data[STAT_TOP_BIT - n] = stat_q[n];
        end
    end

endmodule

// File: rtl/irq_route_checker.sv
`timescale 1ns/1ps
module irq_route_checker #(
    parameter int N_IN = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [2:0]      wr_addr,
    input logic [63:0]     wr_data,
    input logic            ev_valid,
    input logic [2:0]      ev_idx,
    input logic            ev_level,
    input logic [N_IN-1:0] line_out,
    input logic [N_IN-1:0] pend_q,
    input logic [N_IN-1:0] masked_q,
    input logic [N_IN-1:0] stat_q
);

    // R1: lines are quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (line_out == '0));

    // R4: a pending flag never coexists with a mask
    p_pend_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
        (pend_q & masked_q) == '0);

    // R9: an out-of-range event with no write leaves every pending flag
    p_bad_idx_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_idx > 3'd5 && !wr_en) |=> $stable(pend_q));

    // R2: without event or write, pending holds
    p_pend_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ev_valid && !wr_en) |=> $stable(pend_q));

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_per
            // R3: masked write clears pending
            p_mask_clear_r3: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == 3'(i) && (&wr_data[39:32])) |=> !pend_q[i]);
            // R5: status follows the event level
            p_status_r5: assert property (@(posedge clk) disable iff (rst)
                (ev_valid && ev_idx == 3'(i)) |=> (stat_q[i] == $past(ev_level)));
        end
    endgenerate

endmodule

bind irq_route_bank irq_route_checker #(.N_IN(N_IN)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ev_valid (ev_valid),
    .ev_idx   (ev_idx),
    .ev_level (ev_level),
    .line_out (line_out),
    .pend_q   (pend_q),
    .masked_q (masked_q),
    .stat_q   (stat_q)
);

// File: tb/test_irq_route_bank.sv
`timescale 1ns/1ps
module test_irq_route_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_idx = '0;
    logic        ev_level = 1'b0;
    logic        peer_level = 1'b0;
    logic [5:0]  line_out;
    logic [83:0] line_server;
    logic [47:0] line_prio;
    logic [5:0]  line_cfg_valid;

    always #10 clk = ~clk;   // 50 MHz

    irq_route_bank i_irq_route_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_valid(ev_valid), .ev_idx(ev_idx),
        .ev_level(ev_level), .peer_level(peer_level), .line_out(line_out),
        .line_server(line_server), .line_prio(line_prio), .line_cfg_valid(line_cfg_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_srv [6];
    logic [7:0]  m_pri [6];
    logic [2:0]  m_src [6];
    logic        m_pend[6];
    logic        m_st  [6];
    logic        m_peer;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [15:0] s, input logic [7:0] p, input logic [2:0] c);
        return {8'hA5, s, p, c, 5'h1F, 24'hFFFFFF};
    endfunction

    // Sampled at the negedge after the edge that took the stimulus (R10).
    task automatic check_all(input string ctx);
        logic [63:0] e;
        logic [5:0]  el;
        logic [83:0] es;
        logic [47:0] ep;
        logic [5:0]  ev;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            if (a < 6) begin
                e = {8'h0, m_srv[a], m_pri[a], m_src[a], 29'h0};
                chk("R2", {ctx, " fields"}, rd_data & ~(64'h1 << 24), e);
                chk("R4", {ctx, " pending"}, 64'(rd_data[24]), 64'(m_pend[a]));
            end else if (a == 6) begin
                e = (64'(m_peer) << 47) | (64'(m_st[0]) << 46);
                chk("R5", {ctx, " control"}, rd_data, e);
            end else begin
                e = '0;
                for (int n = 1; n < 6; n++) e[37-n] = m_st[n];
                chk("R5", {ctx, " status"}, rd_data, e);
            end
        end
        el = '0; es = '0; ep = '0; ev = '0;
        for (int k = 0; k < 6; k++) begin
            for (int n = 5; n >= 0; n--) begin
                if (m_src[n] == 3'(k)) begin
                    if (n == 0) el[k] = el[k] | m_st[0] | m_peer;
                    else        el[k] = el[k] | m_st[n];
                    es[k*14 +: 14] = m_srv[n][15:2];
                    ep[k*8 +: 8]   = m_pri[n];
                    ev[k]          = 1'b1;
                end
            end
        end
        chk("R7", {ctx, " lines"}, 64'(line_out), 64'(el));
        chk("R8", {ctx, " cfg valid"}, 64'(line_cfg_valid), 64'(ev));
        chk("R8", {ctx, " prio"}, 64'(line_prio), 64'(ep));
        chk("R8", {ctx, " server lo"}, es[63:0], line_server[63:0]);
        chk("R8", {ctx, " server hi"}, 64'(line_server[83:64]), 64'(es[83:64]));
    endtask

    task automatic step(input string ctx, input bit w, input logic [2:0] wa, input logic [63:0] wd,
                        input bit e, input logic [2:0] ei, input bit el, input bit pl);
        logic eff;
        wr_en = w; wr_addr = wa; wr_data = wd;
        ev_valid = e; ev_idx = ei; ev_level = el; peer_level = pl;
        m_peer = pl;
        if (w && wa < 6) begin
            m_srv[wa] = wd[55:40]; m_pri[wa] = wd[39:32]; m_src[wa] = wd[31:29];
        end
        if (e && ei < 6) begin
            m_st[ei] = el;
            eff = (ei == 0) ? (el | pl) : el;
            m_pend[ei] = eff && (m_pri[ei] != 8'hFF);
        end
        for (int n = 0; n < 6; n++) if (m_pri[n] == 8'hFF) m_pend[n] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; ev_valid = 1'b0;
        check_all(ctx);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 6; n++) begin
            m_srv[n] = '0; m_pri[n] = 8'hFF; m_src[n] = 3'(n); m_pend[n] = 0; m_st[n] = 0;
        end
        m_peer = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R2: field write, reserved bits and pending position ignored
        step("R2 write", 1, 3'd2, mk(16'hABCD, 8'h10, 3'd2), 0, 0, 0, 0);
        // R4 and R7: assert input 2
        step("R4 assert", 0, 0, 0, 1, 3'd2, 1, 0);
        // R2: unmasked rewrite keeps pending
        step("R2 keep pend", 1, 3'd2, mk(16'h1234, 8'h20, 3'd2), 0, 0, 0, 0);
        // R3: masked write clears pending, line stays high
        step("R3 mask", 1, 3'd2, mk(16'h1234, 8'hFF, 3'd2), 0, 0, 0, 0);
        step("R4 masked event", 0, 0, 0, 1, 3'd2, 1, 0);
        step("R4 deassert", 0, 0, 0, 1, 3'd2, 0, 0);
        // R6: shared line of input 0 and peer
        step("R6 unmask0", 1, 3'd0, mk(16'h0F0C, 8'h05, 3'd0), 0, 0, 0, 0);
        step("R6 peer up", 0, 0, 0, 0, 0, 0, 1);
        step("R6 own up", 0, 0, 0, 1, 3'd0, 1, 1);
        step("R6 own down", 0, 0, 0, 1, 3'd0, 0, 1);
        step("R6 peer down", 0, 0, 0, 0, 0, 0, 0);
        step("R6 own down again", 0, 0, 0, 1, 3'd0, 0, 0);
        // R9: out-of-range event and write addresses
        step("R9 idx6", 0, 0, 0, 1, 3'd6, 1, 0);
        step("R9 idx7", 0, 0, 0, 1, 3'd7, 1, 0);
        step("R9 addr6", 1, 3'd6, mk(16'hFFFF, 8'h01, 3'd1), 0, 0, 0, 0);
        step("R9 addr7", 1, 3'd7, mk(16'hFFFF, 8'h01, 3'd1), 0, 0, 0, 0);
        // R8: source 7 not forwarded, duplicate source lowest index wins
        step("R8 src7", 1, 3'd4, mk(16'h8888, 8'h44, 3'd7), 0, 0, 0, 0);
        step("R8 src7 assert", 0, 0, 0, 1, 3'd4, 1, 0);
        step("R8 dup", 1, 3'd5, mk(16'h5554, 8'h55, 3'd1), 0, 0, 0, 0);
        step("R8 dup low", 1, 3'd3, mk(16'h3330, 8'h33, 3'd1), 0, 0, 0, 0);
        step("R8 dup assert", 0, 0, 0, 1, 3'd5, 1, 0);

        // near-exhaustive sweep: every input, priority class and source (R10 timing)
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [7:0]  p;
            r = $urandom;
            case (r[1:0])
                2'd0: p = 8'hFF;
                2'd1: p = 8'h00;
                2'd2: p = 8'hFE;
                default: p = r[31:24];
            endcase
            step("R10 sweep", r[2] & r[3], r[6:4], mk(r[23:8], p, r[9:7]),
                 r[10] | r[11], r[14:12], r[15], r[16] & r[17]);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule